// File: doc/BRIEF.md
# Grouped Interrupt Expansion Controller

This block fans a large set of peripheral interrupt requests into a small number of CPU interrupt lines. The sources are split into groups of equal size, and each group drives one line. Every source has a pending flag and an enable bit of its own. Every source also has an entry in a vector table that software can write. Each group has a hold-off bit that stops its line from pulsing again until software releases it.

When the CPU accepts a line, it presents that line number on the acknowledge port. After a fixed fetch latency, the block picks the winning source in that group and returns its vector. The winner is the pending, enabled source with the lowest number. The block clears that source's flag in the same edge. If nothing in the group is pending and enabled at that moment, the block returns a dedicated spurious vector instead.

Top module: `gx_irq_expander`

## Requirements
- R1: After reset, no CPU line is active, no vector is being returned, every source is disabled and every flag is clear. A fetch issued right after reset therefore returns the spurious vector.
- R2: A source's flag is set by a low-to-high transition of its request. A request held high does not set the flag again once a fetch has cleared it.
- R3: A source whose enable bit is 0 never causes a line pulse and is never returned by a fetch. Its flag stays latched, so enabling the source later raises the line and the source can then be returned.
- R4: A group's line pulses high for exactly one cycle. The pulse comes one clock edge after the edge that latched a flag, or one edge after the edge that made a latched flag eligible. The pulse sets the group's hold-off bit. No further pulse occurs on that line until a hold-off clear write releases the bit, and the line pulses again after the release only if an enabled flag is still pending.
- R5: At most one line pulses per cycle. When several groups are eligible together, the lowest-numbered group (line index 0) pulses first, and the next one pulses in the following cycle.
- R6: An acknowledge (`ack_valid` high) is accepted only when no fetch is in progress. An acknowledge that arrives during a fetch is ignored. `vec_valid` pulses for exactly one cycle, FETCH_LAT clock edges after the edge that accepted the acknowledge.
- R7: The winner is decided on the fetch edge, not on the acceptance edge. It is the lowest-numbered pending, enabled source in the acknowledged group. `vec_data` returns that source's table entry, and `vec_src` returns its global index, which is group × GSIZE + position.
- R8: A fetch clears only the winner's flag. Other pending flags in the group remain set and can be returned by later fetches.
- R9: If the acknowledged group has no pending, enabled source at the fetch edge, or if the line number is NGRP or larger, the block returns the spurious vector. In that case `vec_data` = SPUR_VEC, `vec_spur` = 1 and `vec_src` = 0, and no flag is cleared.
- R10: The write port is decoded by `wr_kind`:
  - 0 writes `wr_data` into the vector entry at `wr_addr`.
  - 1 loads `wr_data[GSIZE-1:0]` as the enable bits of group `wr_addr`, with bit i enabling source i of the group.
  - 2 clears the hold-off bit of every group g that has `wr_data[g]` = 1.
  - 3 is ignored.
  
  An address outside the valid range is ignored.
- R11: If a fetch clears a source on the same edge that sees a new rising request from that source, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NGRP*GSIZE | Peripheral request inputs |
| cpu_int | output | NGRP | CPU interrupt lines, one per group, pulsed |
| ack_valid | input | 1 | CPU accepts a line |
| ack_line | input | $clog2(NGRP) | Index of the accepted line |
| vec_valid | output | 1 | Vector result valid, one cycle |
| vec_data | output | VEC_W | Returned vector |
| vec_src | output | $clog2(NGRP*GSIZE) | Global index of the returned source |
| vec_spur | output | 1 | Spurious result marker |
| wr_en | input | 1 | Write strobe |
| wr_kind | input | 2 | Write kind: 0 vector, 1 enable, 2 hold-off clear, 3 none |
| wr_addr | input | $clog2(NGRP*GSIZE) | Source index or group index |
| wr_data | input | VEC_W | Write data |

## Verification
The bench builds the block with its defaults: 12 groups of 8 sources, a 22-bit vector, a fetch latency of 8 and rising-edge capture. These values make the 4-bit line number reach codes beyond the last group, so the out-of-range path can be exercised. The real 8-cycle window lets the bench land a fresh request edge exactly on the fetch edge, and lets it drive a second acknowledge while a fetch is still in flight. The 96 table entries are each loaded with a distinct value, so a wrong winner or a wrong index shows up as a mismatched vector.

// File: rtl/gx_pkg.sv
package gx_pkg;

   typedef enum logic [1:0] {
      WK_VECTOR = 2'd0,
      WK_ENABLE = 2'd1,
      WK_HOLDCL = 2'd2,
      WK_NOP    = 2'd3
   } wr_kind_e;

endpackage

// File: rtl/gx_prio_pick.sv
module gx_prio_pick #(
   parameter int N         = 8,
   parameter int IDX_W     = 3,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic [N-1:0]     req,
   output logic             found,
   output logic [IDX_W-1:0] idx
);

   generate
      if (N < 2) begin : g_bad_n
         $error("gx_prio_pick: N must be at least 2");
      end
      if ((1 << IDX_W) < N) begin : g_bad_w
         $error("gx_prio_pick: IDX_W too narrow for N");
      end

      if (LOW_FIRST) begin : g_low
         always_comb begin
            found = 1'b0;
            idx   = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (req[i]) begin
                  found = 1'b1;
                  idx   = IDX_W'(i);
               end
            end
         end
      end else begin : g_high
         always_comb begin
            found = 1'b0;
            idx   = '0;
            for (int i = 0; i < N; i++) begin
               if (req[i]) begin
                  found = 1'b1;
                  idx   = IDX_W'(i);
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/gx_flag_bank.sv
module gx_flag_bank #(
   parameter int NSRC      = 96,
   parameter bit EDGE_MODE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] req,
   input  logic [NSRC-1:0] clr,
   output logic [NSRC-1:0] flag
);

   logic [NSRC-1:0] set_v;

   generate
      if (NSRC < 1) begin : g_bad
         $error("gx_flag_bank: NSRC must be positive");
      end

      if (EDGE_MODE) begin : g_edge
         logic [NSRC-1:0] req_q;
         always_ff @(posedge clk) begin
            if (!rst_n) req_q <= '0;
            else        req_q <= req;
         end
         assign set_v = req & ~req_q;
      end else begin : g_level
         assign set_v = req;
      end
   endgenerate

   // a fresh set beats a clear on the same edge
   always_ff @(posedge clk) begin
      if (!rst_n) flag <= '0;
      else        flag <= (flag & ~clr) | set_v;
   end

endmodule

// File: rtl/gx_vec_table.sv
module gx_vec_table #(
   parameter int NSRC  = 96,
   parameter int AW    = 7,
   parameter int VEC_W = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [VEC_W-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [VEC_W-1:0] rdata
);

   logic [VEC_W-1:0] mem [NSRC];

   generate
      if ((1 << AW) < NSRC) begin : g_bad
         $error("gx_vec_table: AW too narrow for NSRC");
      end

      for (genvar e = 0; e < NSRC; e++) begin : g_ent
         always_ff @(posedge clk) begin
            if (!rst_n)                        mem[e] <= '0;
            else if (we && waddr == AW'(e))    mem[e] <= wdata;
         end
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int e = 0; e < NSRC; e++) begin
         if (raddr == AW'(e)) rdata = mem[e];
      end
   end

endmodule

// File: rtl/gx_irq_expander.sv
module gx_irq_expander #(
   parameter int               NGRP      = 12,
   parameter int               GSIZE     = 8,
   parameter int               VEC_W     = 22,
   parameter int               FETCH_LAT = 8,
   parameter bit               EDGE_MODE = 1'b1,
   parameter logic [VEC_W-1:0] SPUR_VEC  = 22'h2A5A5,
   localparam int              NSRC      = NGRP * GSIZE,
   localparam int              SRC_W     = $clog2(NSRC),
   localparam int              LINE_W    = $clog2(NGRP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   irq_req,
   output logic [NGRP-1:0]   cpu_int,
   input  logic              ack_valid,
   input  logic [LINE_W-1:0] ack_line,
   output logic              vec_valid,
   output logic [VEC_W-1:0]  vec_data,
   output logic [SRC_W-1:0]  vec_src,
   output logic              vec_spur,
   input  logic              wr_en,
   input  logic [1:0]        wr_kind,
   input  logic [SRC_W-1:0]  wr_addr,
   input  logic [VEC_W-1:0]  wr_data
);

   import gx_pkg::*;

   localparam int GPOS_W = $clog2(GSIZE);
   localparam int CNT_W  = (FETCH_LAT > 1) ? $clog2(FETCH_LAT) : 1;

   generate
      if (NGRP < 2)       begin : g_bad_ngrp  $error("NGRP must be at least 2");          end
      if (GSIZE < 2)      begin : g_bad_gsize $error("GSIZE must be at least 2");         end
      if (FETCH_LAT < 1)  begin : g_bad_lat   $error("FETCH_LAT must be at least 1");     end
      if (VEC_W < GSIZE)  begin : g_bad_vw_g  $error("VEC_W must cover a group's enables"); end
      if (VEC_W < NGRP)   begin : g_bad_vw_n  $error("VEC_W must cover the hold-off mask"); end
   endgenerate

   // ---------------- write decode ----------------
   wr_kind_e kind;
   logic     vec_we, en_we, hold_we;

   assign kind    = wr_kind_e'(wr_kind);
   assign vec_we  = wr_en && (kind == WK_VECTOR);
   assign en_we   = wr_en && (kind == WK_ENABLE);
   assign hold_we = wr_en && (kind == WK_HOLDCL);

   // ---------------- source flags ----------------
   logic [NSRC-1:0] flag;
   logic [NSRC-1:0] clr_v;

   gx_flag_bank #(
      .NSRC      (NSRC),
      .EDGE_MODE (EDGE_MODE)
   ) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (irq_req),
      .clr   (clr_v),
      .flag  (flag)
   );

   // ---------------- per-group enables and pending ----------------
   logic [GSIZE-1:0] en_grp   [NGRP];
   logic [GSIZE-1:0] pend_grp [NGRP];
   logic [NGRP-1:0]  group_pend;

   generate
      for (genvar g = 0; g < NGRP; g++) begin : g_grp
         always_ff @(posedge clk) begin
            if (!rst_n)
               en_grp[g] <= '0;
            else if (en_we && wr_addr == SRC_W'(g))
               en_grp[g] <= wr_data[GSIZE-1:0];
         end
         assign pend_grp[g]   = flag[g*GSIZE +: GSIZE] & en_grp[g];
         assign group_pend[g] = |pend_grp[g];
      end
   endgenerate

   // ---------------- line arbitration and hold-off ----------------
   logic [NGRP-1:0]   hold_q;
   logic [NGRP-1:0]   elig;
   logic [NGRP-1:0]   grant;
   logic [NGRP-1:0]   hold_clr;
   logic              line_found;
   logic [LINE_W-1:0] line_idx;

   assign elig     = group_pend & ~hold_q;
   assign hold_clr = hold_we ? wr_data[NGRP-1:0] : '0;

   gx_prio_pick #(
      .N         (NGRP),
      .IDX_W     (LINE_W),
      .LOW_FIRST (1'b1)
   ) u_line_pick (
      .req   (elig),
      .found (line_found),
      .idx   (line_idx)
   );

   assign grant = line_found ? (NGRP'(1) << line_idx) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q  <= '0;
         cpu_int <= '0;
      end else begin
         hold_q  <= (hold_q & ~hold_clr) | grant;
         cpu_int <= grant;
      end
   end

   // ---------------- fetch sequencing ----------------
   logic              busy;
   logic [CNT_W-1:0]  cnt;
   logic [LINE_W-1:0] acc_line;
   logic              accept;
   logic              fetch_now;

   assign accept    = ack_valid && !busy;
   assign fetch_now = busy && (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cnt      <= '0;
         acc_line <= '0;
      end else if (accept) begin
         busy     <= 1'b1;
         cnt      <= CNT_W'(FETCH_LAT - 1);
         acc_line <= ack_line;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end
   end

   // ---------------- winner selection at the fetch edge ----------------
   logic [GSIZE-1:0]  sel_pend;
   logic              src_found;
   logic [GPOS_W-1:0] src_pos;
   logic [SRC_W-1:0]  win_src;
   logic [VEC_W-1:0]  tbl_data;

   always_comb begin
      sel_pend = '0;
      for (int g = 0; g < NGRP; g++) begin
         if (acc_line == LINE_W'(g)) sel_pend = pend_grp[g];
      end
   end

   gx_prio_pick #(
      .N         (GSIZE),
      .IDX_W     (GPOS_W),
      .LOW_FIRST (1'b1)
   ) u_src_pick (
      .req   (sel_pend),
      .found (src_found),
      .idx   (src_pos)
   );

   assign win_src = SRC_W'(acc_line) * SRC_W'(GSIZE) + SRC_W'(src_pos);
   assign clr_v   = (fetch_now && src_found) ? (NSRC'(1) << win_src) : '0;

   gx_vec_table #(
      .NSRC  (NSRC),
      .AW    (SRC_W),
      .VEC_W (VEC_W)
   ) u_table (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (vec_we),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (win_src),
      .rdata (tbl_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_valid <= 1'b0;
         vec_data  <= '0;
         vec_src   <= '0;
         vec_spur  <= 1'b0;
      end else begin
         vec_valid <= fetch_now;
         if (fetch_now) begin
            vec_data <= src_found ? tbl_data : SPUR_VEC;
            vec_src  <= src_found ? win_src  : '0;
            vec_spur <= !src_found;
         end
      end
   end

endmodule

// File: rtl/gx_irq_expander_chk.sv
module gx_irq_expander_chk #(
   parameter int               NGRP      = 12,
   parameter int               VEC_W     = 22,
   parameter int               SRC_W     = 7,
   parameter int               FETCH_LAT = 8,
   parameter logic [VEC_W-1:0] SPUR_VEC  = '0
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NGRP-1:0]  cpu_int,
   input logic [NGRP-1:0]  grp_pend,
   input logic             ack_valid,
   input logic             vec_valid,
   input logic [VEC_W-1:0] vec_data,
   input logic [SRC_W-1:0] vec_src,
   input logic             vec_spur
);

   localparam int MW = $clog2(FETCH_LAT + 1);

   // independent model of the fetch window, driven from the port only
   logic          m_busy;
   logic [MW-1:0] m_cnt;
   logic          m_due;

   assign m_due = m_busy && (m_cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_busy <= 1'b0;
         m_cnt  <= '0;
      end else if (ack_valid && !m_busy) begin
         m_busy <= 1'b1;
         m_cnt  <= MW'(FETCH_LAT - 1);
      end else if (m_busy) begin
         if (m_cnt == '0) m_busy <= 1'b0;
         else             m_cnt  <= m_cnt - 1'b1;
      end
   end

   p_one_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cpu_int));

   p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_int & $past(cpu_int)) == '0);

   p_line_from_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_int & ~$past(grp_pend)) == '0);

   p_fetch_due_r6: assert property (@(posedge clk) disable iff (!rst_n)
      m_due |=> vec_valid);

   p_fetch_only_when_due_r6: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> $past(m_due));

   p_spurious_shape_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_valid && vec_spur) |-> (vec_data == SPUR_VEC && vec_src == '0));

endmodule

bind gx_irq_expander gx_irq_expander_chk #(
   .NGRP      (NGRP),
   .VEC_W     (VEC_W),
   .SRC_W     (SRC_W),
   .FETCH_LAT (FETCH_LAT),
   .SPUR_VEC  (SPUR_VEC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_int   (cpu_int),
   .grp_pend  (group_pend),
   .ack_valid (ack_valid),
   .vec_valid (vec_valid),
   .vec_data  (vec_data),
   .vec_src   (vec_src),
   .vec_spur  (vec_spur)
);

// File: tb/tb_gx_irq_expander.sv
`timescale 1ns/1ps
module tb_gx_irq_expander;

   localparam int NGRP = 12;
   localparam int GSIZE = 8;
   localparam int NSRC = 96;
   localparam int VEC_W = 22;
   localparam int LAT = 8;
   localparam logic [21:0] SPUR = 22'h2A5A5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [95:0] irq_req = '0;
   logic [11:0] cpu_int;
   logic        ack_valid = 1'b0;
   logic [3:0]  ack_line = '0;
   logic        vec_valid;
   logic [21:0] vec_data;
   logic [6:0]  vec_src;
   logic        vec_spur;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_kind = '0;
   logic [6:0]  wr_addr = '0;
   logic [21:0] wr_data = '0;

   int errs = 0;
   int checks = 0;
   int cyc = 0;
   bit done = 1'b0;

   typedef struct {
      int          at;
      logic [6:0]  src;
      logic [21:0] vec;
      bit          spur;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   gx_irq_expander dut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .cpu_int(cpu_int),
      .ack_valid(ack_valid), .ack_line(ack_line), .vec_valid(vec_valid),
      .vec_data(vec_data), .vec_src(vec_src), .vec_spur(vec_spur),
      .wr_en(wr_en), .wr_kind(wr_kind), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   function automatic logic [21:0] vof(int s);
      return 22'h10000 + 22'(s * 5);
   endfunction

   task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(logic [1:0] k, logic [6:0] a, logic [21:0] d);
      wr_en = 1'b1; wr_kind = k; wr_addr = a; wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   // driver: push the expected result, then present the acknowledge
   task automatic fetch(logic [3:0] line, logic [6:0] s, logic [21:0] v, bit sp, string tag);
      exp_t e;
      e.at = cyc + 1 + LAT; e.src = s; e.vec = v; e.spur = sp; e.tag = tag;
      sb.push_back(e);
      ack_valid = 1'b1; ack_line = line;
      tick();
      ack_valid = 1'b0;
   endtask

   task automatic drain();
      repeat (LAT + 3) tick();
   endtask

   // monitor: pop and compare as results appear
   always @(negedge clk) begin
      if (rst_n && vec_valid && !done) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R6 unexpected vector", 64'(vec_src), 64'hFFFF);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(cyc == e.at, {e.tag, " latency"}, 64'(cyc), 64'(e.at));
            chk(vec_src == e.src && vec_data == e.vec && vec_spur == e.spur,
                {e.tag, " result"}, {vec_spur, vec_src, vec_data}, {e.spur, e.src, e.vec});
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         errs++; checks++;
         $display("FAIL watchdog act=1 exp=0");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1
      chk(cpu_int == '0, "R1 lines idle", 64'(cpu_int), 0);
      chk(vec_valid == 1'b0, "R1 no vector", 64'(vec_valid), 0);
      fetch(4'd0, 7'd0, SPUR, 1'b1, "R1 fetch after reset");
      drain();

      for (int s = 0; s < NSRC; s++) wr(2'd0, 7'(s), vof(s));
      chk(cpu_int == '0, "R1 still idle", 64'(cpu_int), 0);

      // R3 disabled source latches but stays quiet
      irq_req[5] = 1'b1;
      repeat (4) tick();
      chk(cpu_int == '0, "R3 disabled quiet", 64'(cpu_int), 0);
      wr(2'd1, 7'd0, 22'hFF);
      tick();
      chk(cpu_int == 12'h001, "R3 enable raises line", 64'(cpu_int), 1);
      tick();
      chk(cpu_int == '0, "R4 single pulse", 64'(cpu_int), 0);
      repeat (3) tick();
      chk(cpu_int == '0, "R4 hold-off", 64'(cpu_int), 0);
      fetch(4'd0, 7'd5, vof(5), 1'b0, "R7 single source");
      drain();
      wr(2'd2, 7'd0, 22'h001);
      repeat (3) tick();
      chk(cpu_int == '0, "R8 flag cleared no repulse", 64'(cpu_int), 0);
      fetch(4'd0, 7'd0, SPUR, 1'b1, "R2 held level no reset");
      drain();
      irq_req[5] = 1'b0;

      // R7 priority inside a group, R8 remaining flag
      irq_req[3] = 1'b1; irq_req[6] = 1'b1;
      tick(); tick();
      chk(cpu_int == 12'h001, "R4 repulse after release", 64'(cpu_int), 1);
      fetch(4'd0, 7'd3, vof(3), 1'b0, "R7 lowest wins");
      drain();
      fetch(4'd0, 7'd6, vof(6), 1'b0, "R8 other flag kept");
      drain();
      fetch(4'd0, 7'd0, SPUR, 1'b1, "R9 group empty");
      drain();
      irq_req[3] = 1'b0; irq_req[6] = 1'b0;
      wr(2'd2, 7'd0, 22'h001);

      // R5 line ordering
      wr(2'd1, 7'd2, 22'hFF);
      wr(2'd1, 7'd7, 22'hFF);
      irq_req[58] = 1'b1; irq_req[17] = 1'b1;
      tick(); tick();
      chk(cpu_int == 12'h004, "R5 lowest line first", 64'(cpu_int), 64'h004);
      tick();
      chk(cpu_int == 12'h080, "R5 next line", 64'(cpu_int), 64'h080);
      tick();
      chk(cpu_int == '0, "R5 done", 64'(cpu_int), 0);
      fetch(4'd7, 7'd58, vof(58), 1'b0, "R5 group7");
      drain();
      fetch(4'd2, 7'd17, vof(17), 1'b0, "R5 group2");
      drain();
      irq_req[58] = 1'b0; irq_req[17] = 1'b0;

      // R6 acknowledge during a fetch is ignored
      irq_req[20] = 1'b1; irq_req[60] = 1'b1;
      tick(); tick();
      fetch(4'd2, 7'd20, vof(20), 1'b0, "R6 first fetch");
      ack_valid = 1'b1; ack_line = 4'd7;
      tick();
      ack_valid = 1'b0;
      drain();
      fetch(4'd7, 7'd60, vof(60), 1'b0, "R6 ignored ack kept flag");
      drain();
      irq_req[20] = 1'b0; irq_req[60] = 1'b0;

      // R9 line out of range
      wr(2'd1, 7'd3, 22'hFF);
      irq_req[30] = 1'b1;
      tick(); tick();
      fetch(4'd13, 7'd0, SPUR, 1'b1, "R9 line out of range");
      drain();
      fetch(4'd3, 7'd30, vof(30), 1'b0, "R9 no flag cleared");
      drain();
      irq_req[30] = 1'b0;

      // R10 write kinds
      wr(2'd1, 7'd1, 22'hFF);
      wr(2'd3, 7'd9, 22'h3ABCD);
      wr(2'd0, 7'd100, 22'h3ABCD);
      irq_req[9] = 1'b1;
      tick(); tick();
      fetch(4'd1, 7'd9, vof(9), 1'b0, "R10 kind3 and bad address ignored");
      drain();
      wr(2'd0, 7'd9, 22'h0BEEF);
      irq_req[9] = 1'b0; tick();
      irq_req[9] = 1'b1; tick(); tick();
      fetch(4'd1, 7'd9, 22'h0BEEF, 1'b0, "R10 vector rewrite");
      drain();
      irq_req[9] = 1'b0;

      // R3 per-source enable inside a group
      wr(2'd1, 7'd1, 22'hFE);
      irq_req[8] = 1'b1; irq_req[10] = 1'b1;
      tick(); tick();
      fetch(4'd1, 7'd10, vof(10), 1'b0, "R3 disabled skipped");
      drain();
      fetch(4'd1, 7'd0, SPUR, 1'b1, "R3 disabled not returned");
      drain();
      wr(2'd1, 7'd1, 22'hFF);
      tick();
      fetch(4'd1, 7'd8, vof(8), 1'b0, "R3 latched flag returned");
      drain();
      irq_req[8] = 1'b0; irq_req[10] = 1'b0;

      // R11 new edge on the fetch edge
      wr(2'd1, 7'd5, 22'hFF);
      irq_req[40] = 1'b1; tick();
      irq_req[40] = 1'b0; tick();
      fetch(4'd5, 7'd40, vof(40), 1'b0, "R11 first");
      repeat (LAT - 1) tick();
      irq_req[40] = 1'b1; tick();
      irq_req[40] = 1'b0;
      drain();
      fetch(4'd5, 7'd40, vof(40), 1'b0, "R11 set wins");
      drain();

      chk(sb.size() == 0, "R6 all results seen", 64'(sb.size()), 0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule